// File: doc/BRIEF.md
# Routed Event Interrupt Controller

This controller collects a vector of active-high, level-sensitive event lines and routes them to host interrupt lines through two programmable hops. Each event is assigned to a channel, and each channel is assigned to a host line. Every event has a pending bit and an enable bit. Each host line carries an enable. One global switch gates all of the host lines.

Software uses a 32-bit register bus. A write takes one cycle, marked by a strobe. A read returns its data one cycle after the read strobe. A single event can be set, cleared, enabled or disabled by writing its number to an indexed register. The same state can also be reached 32 events at a time through bitmap words. For each host there is a read-only word that reports the highest-priority enabled pending event routed to it, or reports that none is waiting. A host output rises one cycle after the conditions for it are met.

Top module: `evt_route_intc`

## Requirements
- R1: After reset, all host outputs are 0, all pending, enable, host-enable and global-enable state is 0, every map field reads 0, and each priority word reads 0x8000_0000.
- R2: While an event input is high, its pending bit is set and stays set even when a clear is written. After the input falls, the bit stays set until it is cleared.
- R3: Writing an event number to offset 0x004 sets that event's pending bit. Writing it to 0x008 clears the bit. A number at or above the event count changes nothing.
- R4: Writing an event number to 0x00C enables that event, and writing it to 0x010 disables it. At offset 0x200+4w, each 1 bit written enables an event; at 0x300+4w, each 1 bit written disables one. Both offsets read back the enable word.
- R5: The word at 0x100+4w reads the pending bits of events 32w to 32w+31, with event e at bit e%32. Writing 1 to a bit there clears that pending bit.
- R6: The channel-map word at 0x400+4i holds events 4i to 4i+3, one per byte lane, with event e in lane e%4. Only the low 4 bits of each lane are stored, and they hold the channel number.
- R7: The host-map word at 0x500+4i holds channels 4i to 4i+3 in the same lane layout. The low 4 bits of each lane hold the host number.
- R8: The priority word for host h, at 0x600+4h, reads 0x8000_0000 when no enabled pending event routes to h. Otherwise bits 9:0 give the winning event. The lowest channel routed to h that has any candidate wins, and within that channel the lowest event number wins.
- R9: A host output is high exactly one cycle after global enable, that host's enable, and a valid priority word all hold together.
- R10: Writing a host number to 0x014 enables that host output, and writing it to 0x018 disables it.
- R11: Bit 0 of the register at 0x000 is the global enable. While it is 0, every host output stays low.
- R12: Read data appears on the cycle after the read strobe, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 13 | Byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| evtIn | input | 64 | Level event inputs, active high |
| hostIrq | output | 10 | Host interrupt outputs |

## Verification
The router is exercised with two pending events on different channels that share one host. Here the higher-numbered event sits on the lower channel, which shows whether the channel or the event number is compared first. Two events on the same channel then show ordering by event number, and clearing the winners one at a time shows that the search moves on to the next candidate. Pending state is driven three ways: by the input pins, by indexed writes and by bitmap writes. The bench then compares a clear written while the input is high with a clear written after the input falls. The host output is sampled both in the cycle of the enabling write and in the cycle after it, to confirm the one-cycle delay and the gating by each enable.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
  localparam int IDX_W = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_GLB, RD_STAT, RD_EN, RD_CHMAP, RD_HOMAP, RD_PRIO
  } rdSel_t;

  typedef struct packed {
    logic glbWr;
    logic stSet;
    logic stClr;
    logic enSet;
    logic enClr;
    logic hoSet;
    logic hoClr;
    logic stW1c;
    logic enW1s;
    logic enW1c;
    logic chMapWr;
    logic hoMapWr;
    logic rdStb;
    rdSel_t rdSel;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/evt_route_ctrl.sv
module evt_route_ctrl
  import evt_route_pkg::*;
#(
  parameter int NUM_EVENTS   = 64,
  parameter int NUM_CHANNELS = 10,
  parameter int NUM_HOSTS    = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [12:0] addr,
  output strobe_t     stb
);
  localparam int EVT_WORDS = (NUM_EVENTS + 31) / 32;
  localparam int CMAP_REGS = (NUM_EVENTS + 3) / 4;
  localparam int HMAP_REGS = (NUM_CHANNELS + 3) / 4;

  logic [4:0] region;
  logic [IDX_W-1:0] word;
  assign region = addr[12:8];
  assign word   = addr[7:2];

  always_comb begin
    stb = '0;
    stb.idx = word;
    stb.rdStb = rdEn;
    stb.rdSel = RD_NONE;
    if (addr[7:2] == word && addr[1:0] == 2'b00) begin
      unique case (region)
        5'd0: begin
          if (word == 0) stb.rdSel = RD_GLB;
          if (wrEn) begin
            stb.glbWr = (word == 0);
            stb.stSet = (word == 1);
            stb.stClr = (word == 2);
            stb.enSet = (word == 3);
            stb.enClr = (word == 4);
            stb.hoSet = (word == 5);
            stb.hoClr = (word == 6);
          end
        end
        5'd1: if (int'(word) < EVT_WORDS) begin
          stb.rdSel = RD_STAT;
          stb.stW1c = wrEn;
        end
        5'd2: if (int'(word) < EVT_WORDS) begin
          stb.rdSel = RD_EN;
          stb.enW1s = wrEn;
        end
        5'd3: if (int'(word) < EVT_WORDS) begin
          stb.rdSel = RD_EN;
          stb.enW1c = wrEn;
        end
        5'd4: if (int'(word) < CMAP_REGS) begin
          stb.rdSel = RD_CHMAP;
          stb.chMapWr = wrEn;
        end
        5'd5: if (int'(word) < HMAP_REGS) begin
          stb.rdSel = RD_HOMAP;
          stb.hoMapWr = wrEn;
        end
        5'd6: if (int'(word) < NUM_HOSTS) stb.rdSel = RD_PRIO;
        default: ;
      endcase
    end
  end

  // R12: one bus access touches at most one register
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.glbWr, stb.stSet, stb.stClr, stb.enSet, stb.enClr, stb.hoSet,
              stb.hoClr, stb.stW1c, stb.enW1s, stb.enW1c, stb.chMapWr, stb.hoMapWr}));
endmodule

// File: rtl/evt_route_datapath.sv
module evt_route_datapath
  import evt_route_pkg::*;
#(
  parameter int NUM_EVENTS   = 64,
  parameter int NUM_CHANNELS = 10,
  parameter int NUM_HOSTS    = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [31:0]           wrData,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic [31:0]           rdData,
  output logic [NUM_HOSTS-1:0]  hostIrq
);
  localparam int EVT_WORDS = (NUM_EVENTS + 31) / 32;
  localparam int PAD_BITS  = EVT_WORDS * 32;

  logic [NUM_EVENTS-1:0]   pending, pendNxt, enable, enNxt;
  logic [NUM_HOSTS-1:0]    hostEn, hostHit;
  logic                    globalEn;
  logic [3:0]              chMap [NUM_EVENTS];
  logic [3:0]              hoMap [NUM_CHANNELS];
  logic [NUM_CHANNELS-1:0] chHit;
  logic [9:0]              chEvt   [NUM_CHANNELS];
  logic [9:0]              hostEvt [NUM_HOSTS];
  logic [PAD_BITS-1:0]     pendPad, enPad;
  logic [31:0]             rdNext;

  // Next pending / enable state
  always_comb begin
    for (int e = 0; e < NUM_EVENTS; e++) begin
      logic hitIdx, setBit, clrBit;
      hitIdx = (wrData == 32'(e));
      setBit = stb.stSet && hitIdx;
      clrBit = (stb.stClr && hitIdx) ||
               (stb.stW1c && int'(stb.idx) == e / 32 && wrData[e % 32]);
      pendNxt[e] = evtIn[e] || setBit || (pending[e] && !clrBit);
      enNxt[e] = enable[e];
      if ((stb.enSet && hitIdx) ||
          (stb.enW1s && int'(stb.idx) == e / 32 && wrData[e % 32])) enNxt[e] = 1'b1;
      if ((stb.enClr && hitIdx) ||
          (stb.enW1c && int'(stb.idx) == e / 32 && wrData[e % 32])) enNxt[e] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      enable   <= '0;
      hostEn   <= '0;
      globalEn <= 1'b0;
      for (int e = 0; e < NUM_EVENTS; e++) chMap[e] <= '0;
      for (int c = 0; c < NUM_CHANNELS; c++) hoMap[c] <= '0;
    end else begin
      pending <= pendNxt;
      enable  <= enNxt;
      if (stb.glbWr) globalEn <= wrData[0];
      for (int h = 0; h < NUM_HOSTS; h++) begin
        if (stb.hoSet && wrData == 32'(h)) hostEn[h] <= 1'b1;
        if (stb.hoClr && wrData == 32'(h)) hostEn[h] <= 1'b0;
      end
      for (int l = 0; l < 4; l++) begin
        if (stb.chMapWr && int'(stb.idx) * 4 + l < NUM_EVENTS)
          chMap[int'(stb.idx) * 4 + l] <= wrData[8*l +: 4];
        if (stb.hoMapWr && int'(stb.idx) * 4 + l < NUM_CHANNELS)
          hoMap[int'(stb.idx) * 4 + l] <= wrData[8*l +: 4];
      end
    end
  end

  // Stage 1: lowest enabled pending event per channel
  always_comb begin
    for (int c = 0; c < NUM_CHANNELS; c++) begin
      chHit[c] = 1'b0;
      chEvt[c] = '0;
      for (int e = NUM_EVENTS - 1; e >= 0; e--) begin
        if (pending[e] && enable[e] && chMap[e] == 4'(c)) begin
          chHit[c] = 1'b1;
          chEvt[c] = 10'(e);
        end
      end
    end
  end

  // Stage 2: lowest active channel per host
  always_comb begin
    for (int h = 0; h < NUM_HOSTS; h++) begin
      hostHit[h] = 1'b0;
      hostEvt[h] = '0;
      for (int c = NUM_CHANNELS - 1; c >= 0; c--) begin
        if (chHit[c] && hoMap[c] == 4'(h)) begin
          hostHit[h] = 1'b1;
          hostEvt[h] = chEvt[c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostIrq <= '0;
    else       hostIrq <= hostHit & hostEn & {NUM_HOSTS{globalEn}};
  end

  // Read path
  assign pendPad = PAD_BITS'(pending);
  assign enPad   = PAD_BITS'(enable);

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      RD_GLB:  rdNext = {31'b0, globalEn};
      RD_STAT: for (int w = 0; w < EVT_WORDS; w++)
                 if (int'(stb.idx) == w) rdNext = pendPad[32*w +: 32];
      RD_EN:   for (int w = 0; w < EVT_WORDS; w++)
                 if (int'(stb.idx) == w) rdNext = enPad[32*w +: 32];
      RD_CHMAP: for (int l = 0; l < 4; l++)
                 if (int'(stb.idx) * 4 + l < NUM_EVENTS)
                   rdNext[8*l +: 4] = chMap[int'(stb.idx) * 4 + l];
      RD_HOMAP: for (int l = 0; l < 4; l++)
                 if (int'(stb.idx) * 4 + l < NUM_CHANNELS)
                   rdNext[8*l +: 4] = hoMap[int'(stb.idx) * 4 + l];
      RD_PRIO: for (int h = 0; h < NUM_HOSTS; h++)
                 if (int'(stb.idx) == h)
                   rdNext = hostHit[h] ? {22'b0, hostEvt[h]} : 32'h8000_0000;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= rdNext;
  end

  // R11: no host line rises unless global enable was on
  assert_global_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (hostIrq != '0) |-> $past(globalEn));

  // R12: unmapped read returns zero
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(stb.rdStb) && $past(stb.rdSel) == RD_NONE) |-> rdData == '0);

  // R2: a high input leaves its pending bit set on the next cycle
  assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((pending & $past(evtIn)) == $past(evtIn)));

  // R10: a host line only rises for an enabled host
  assert_host_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((hostIrq & ~$past(hostEn)) == '0));
endmodule

// File: rtl/evt_route_intc.sv
module evt_route_intc
  import evt_route_pkg::*;
#(
  parameter int NUM_EVENTS   = 64,
  parameter int NUM_CHANNELS = 10,
  parameter int NUM_HOSTS    = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [12:0]           addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  input  logic [NUM_EVENTS-1:0] evtIn,
  output logic [NUM_HOSTS-1:0]  hostIrq
);
  strobe_t stb;

  evt_route_ctrl #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS), .NUM_HOSTS(NUM_HOSTS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  evt_route_datapath #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_CHANNELS(NUM_CHANNELS), .NUM_HOSTS(NUM_HOSTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .evtIn(evtIn),
    .rdData(rdData), .hostIrq(hostIrq)
  );
endmodule

// File: tb/evt_route_intc_bench.sv
module evt_route_intc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] evtIn = '0;
  logic [9:0]  hostIrq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_route_intc u_evt_route_intc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 hostIrq", 32'(hostIrq), 0);
    busRead(13'h600, d); check("R1 prio host0", d, 32'h8000_0000);
    busRead(13'h400, d); check("R1 chmap0", d, 0);
    busRead(13'h100, d); check("R1 status0", d, 0);
  endtask

  task automatic testIndexedStatus();
    logic [31:0] d;
    busWrite(13'h004, 5);
    busRead(13'h100, d); check("R3 set ev5", d, 32'h20);
    busWrite(13'h008, 5);
    busRead(13'h100, d); check("R3 clr ev5", d, 0);
    busWrite(13'h004, 40);
    busRead(13'h104, d); check("R5 ev40 word1 bit8", d, 32'h100);
    busWrite(13'h100 + 13'h4, 32'h100);
    busRead(13'h104, d); check("R5 w1c ev40", d, 0);
    busWrite(13'h004, 70);
    busRead(13'h100, d); check("R3 out-of-range w0", d, 0);
    busRead(13'h104, d); check("R3 out-of-range w1", d, 0);
  endtask

  task automatic testLevel();
    logic [31:0] d;
    @(negedge clk); evtIn[3] = 1'b1;
    busRead(13'h100, d); check("R2 input sets pend", d, 32'h8);
    busWrite(13'h008, 3);
    busRead(13'h100, d); check("R2 clear while high", d, 32'h8);
    @(negedge clk); evtIn[3] = 1'b0;
    busRead(13'h100, d); check("R2 held after fall", d, 32'h8);
    busWrite(13'h100, 32'h8);
    busRead(13'h100, d); check("R2 cleared after fall", d, 0);
  endtask

  task automatic testEnable();
    logic [31:0] d;
    busWrite(13'h00C, 7);
    busRead(13'h200, d); check("R4 idx enable ev7", d, 32'h80);
    busWrite(13'h204, 32'h3);
    busRead(13'h204, d); check("R4 w1s word1", d, 32'h3);
    busWrite(13'h304, 32'h1);
    busRead(13'h304, d); check("R4 w1c word1", d, 32'h2);
    busWrite(13'h010, 7);
    busWrite(13'h010, 33);
    busRead(13'h200, d); check("R4 idx disable w0", d, 0);
    busRead(13'h204, d); check("R4 idx disable w1", d, 0);
  endtask

  task automatic testMaps();
    logic [31:0] d;
    busWrite(13'h404, 32'hFF0A_F307);
    busRead(13'h404, d); check("R6 lane masking", d, 32'h0F0A_0307);
    busWrite(13'h404, 0);
    busWrite(13'h508, 32'hFFFF_F2F1);
    busRead(13'h508, d); check("R7 host map ch8/9 only", d, 32'h0000_0201);
    busWrite(13'h508, 0);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    busWrite(13'h408, 32'h0505_0000); // events 10,11 -> channel 5
    busWrite(13'h414, 32'h0000_0002); // event 20 -> channel 2
    busWrite(13'h500, 32'h0001_0000); // channel 2 -> host 1
    busWrite(13'h504, 32'h0000_0100); // channel 5 -> host 1
    busWrite(13'h00C, 10); busWrite(13'h00C, 11); busWrite(13'h00C, 20);
    busWrite(13'h004, 10); busWrite(13'h004, 20);
    busRead(13'h604, d); check("R8 lower channel wins", d, 20);
    busWrite(13'h008, 20);
    busRead(13'h604, d); check("R8 next candidate", d, 10);
    busWrite(13'h004, 11);
    busRead(13'h604, d); check("R8 lower event in channel", d, 10);
    busWrite(13'h008, 10);
    busRead(13'h604, d); check("R8 event 11", d, 11);
    busWrite(13'h008, 11);
    busRead(13'h604, d); check("R8 none pending", d, 32'h8000_0000);
    busWrite(13'h004, 12);
    busRead(13'h600, d); check("R8 disabled not reported", d, 32'h8000_0000);
    busWrite(13'h008, 12);
  endtask

  task automatic testHostOut();
    busWrite(13'h004, 10);
    busWrite(13'h014, 1);
    @(negedge clk); check("R11 global off", 32'(hostIrq), 0);
    busWrite(13'h000, 1);
    check("R9 latency one cycle", 32'(hostIrq), 0);
    @(negedge clk); check("R9 asserted", 32'(hostIrq), 32'h2);
    busWrite(13'h018, 1);
    @(negedge clk); check("R10 host disabled", 32'(hostIrq), 0);
    busWrite(13'h014, 1);
    @(negedge clk); check("R10 host re-enabled", 32'(hostIrq), 32'h2);
    busWrite(13'h010, 10);
    @(negedge clk); check("R4 event disable drops line", 32'(hostIrq), 0);
    busWrite(13'h00C, 10);
    busWrite(13'h000, 0);
    @(negedge clk); check("R11 global cleared", 32'(hostIrq), 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busRead(13'h000, d); check("R11 global reads 0", d, 0);
    busRead(13'h7F0, d); check("R12 unmapped region", d, 0);
    busRead(13'h630, d); check("R12 host 12 unmapped", d, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIndexedStatus();
    testLevel();
    testEnable();
    testMaps();
    testPriority();
    testHostOut();
    testUnmapped();
    finishRun();
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule